// File: doc/BRIEF.md
# Masked Event Interrupt Register

This block collects one-cycle event pulses from the units around it (transmit, receive, management and bus logic) into a bank of sticky flags. A simple register port reads the flags and a 32-bit enable mask, replaces the mask, and clears flags with write-one-to-clear. Thirteen dedicated interrupt lines each follow one flag gated by its mask bit. The lines come from a fixed, scattered set of flags.

Only flag bits 31 down to 19 are implemented. A write of bit 0 to the transmit control address is a graceful-stop request. Because the block stops at once, the request acknowledges itself by raising the graceful-stop flag (bit 28) in the same cycle.

The port is single-cycle. Register addresses are 0 for flags, 1 for mask and 2 for transmit control. Read data depends on the address alone.

Top module: `evt_irq_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, the flags, the mask and all interrupt lines read zero.
- R2: A set pulse on any bit from 31 down to 19 latches that flag at the next clock edge. The flag then reads as 1 at address 0 until it is cleared.
- R3: Flag bits 18 to 0 always read zero, and set pulses on them have no effect.
- R4: A write to address 0 clears every flag whose written data bit is 1 and leaves all other flags as they were.
- R5: A write to address 1 replaces all 32 mask bits, and address 1 reads the mask back.
- R6: Line i is high exactly when its source flag and the mask bit at the same position are both 1. The sources for lines 0 to 12, in order, are bits 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30.
- R7: The lines are registered. They change one clock edge after the flag or mask change that causes them.
- R8: A write to address 2 with data bit 0 set raises flag 28 at the same edge. A write there with bit 0 clear changes no flag.
- R9: When a set pulse and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R10: Reads of addresses 2 and 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_set_i | input | 32 | Per-flag set pulses from the event sources |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write enable, used together with bus_sel_i |
| bus_addr_i | input | 2 | Register address: 0 flags, 1 mask, 2 transmit control |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 13 | Interrupt lines |

## Verification
The hardest case to reach is a set pulse and a clear write landing on the same flag in the same cycle. The bench drives both on one falling edge before the rising edge that resolves them. It sweeps every flag position with single-bit pulses. It then sweeps every line with a mask that admits only that line's source, and again with a mask that admits all but that source. These two sweeps expose any swapped or misrouted mapping entry. Each line is sampled both on the edge where its flag changes and on the edge after, so that the one-cycle lag is checked as well.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned NUM_LINES = 13;
  localparam int unsigned FLAG_LO   = 19;
  localparam int unsigned BIT_GSTOP = 28;
  localparam int unsigned ADDR_W    = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_FLAGS = 2'd0,
    ADDR_MASK  = 2'd1,
    ADDR_TXCTL = 2'd2,
    ADDR_SPARE = 2'd3
  } reg_addr_e;

  // Flag position that drives each interrupt line.
  function automatic int unsigned line_src(input int unsigned idx);
    case (idx)
      0:       return 27;
      1:       return 26;
      2:       return 19;
      3:       return 20;
      4:       return 25;
      5:       return 24;
      6:       return 23;
      7:       return 21;
      8:       return 31;
      9:       return 28;
      10:      return 22;
      11:      return 29;
      default: return 30;
    endcase
  endfunction
endpackage

// File: rtl/evt_flag_reg.sv
module evt_flag_reg
  import evt_irq_pkg::*;
#(
  parameter int unsigned WIDTH = REG_W,
  parameter int unsigned LO    = FLAG_LO
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flags_o
);
  localparam int unsigned          IMPL_W    = WIDTH - LO;
  localparam logic [WIDTH-1:0]     IMPL_MASK = {{IMPL_W{1'b1}}, {LO{1'b0}}};

  logic [WIDTH-1:0] flags_q, flags_d;
  logic             upd_en;

  // Set overrides clear on the same bit.
  always_comb begin
    flags_d = ((flags_q & ~clr_i) | set_i) & IMPL_MASK;
    upd_en  = |((set_i | clr_i) & IMPL_MASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flags_q <= '0;
    else if (upd_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg
  import evt_irq_pkg::*;
#(
  parameter int unsigned WIDTH = REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] mask_o
);
  logic [WIDTH-1:0] mask_q, mask_d;

  always_comb mask_d = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_en_i) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/evt_line_map.sv
module evt_line_map
  import evt_irq_pkg::*;
#(
  parameter int unsigned WIDTH = REG_W,
  parameter int unsigned LINES = NUM_LINES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] flags_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic [LINES-1:0] irq_o
);
  logic [WIDTH-1:0] active;
  logic [LINES-1:0] irq_d, irq_q;
  logic             irq_en;

  always_comb active = flags_i & mask_i;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    localparam int unsigned SRC = line_src(i);
    assign irq_d[i] = active[SRC];
  end

  always_comb irq_en = (irq_d != irq_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     irq_q <= '0;
    else if (irq_en) irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned WIDTH = REG_W,
  parameter int unsigned LINES = NUM_LINES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDTH-1:0]  evt_set_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WIDTH-1:0]  bus_wdata_i,
  output logic [WIDTH-1:0]  bus_rdata_o,
  output logic [LINES-1:0]  irq_o
);
  logic [WIDTH-1:0] flags_q, mask_q;
  logic [WIDTH-1:0] set_vec, clr_vec;
  logic             wr_flags, wr_mask, wr_txctl;

  always_comb begin
    wr_flags = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_FLAGS);
    wr_mask  = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_MASK);
    wr_txctl = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_TXCTL);
    clr_vec  = wr_flags ? bus_wdata_i : '0;
    set_vec  = evt_set_i;
    // Graceful stop completes at once: acknowledge in the same edge.
    if (wr_txctl && bus_wdata_i[0]) set_vec[BIT_GSTOP] = 1'b1;
  end

  evt_flag_reg #(.WIDTH(WIDTH), .LO(FLAG_LO)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .flags_o (flags_q)
  );

  evt_mask_reg #(.WIDTH(WIDTH)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_mask),
    .wdata_i (bus_wdata_i),
    .mask_o  (mask_q)
  );

  evt_line_map #(.WIDTH(WIDTH), .LINES(LINES)) u_lines (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flags_i (flags_q),
    .mask_i  (mask_q),
    .irq_o   (irq_o)
  );

  always_comb begin
    case (bus_addr_i)
      ADDR_FLAGS: bus_rdata_o = flags_q;
      ADDR_MASK:  bus_rdata_o = mask_q;
      default:    bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
  import evt_irq_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [REG_W-1:0]     evt_set_i,
  input logic                 bus_sel_i,
  input logic                 bus_we_i,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic [REG_W-1:0]     bus_wdata_i,
  input logic [REG_W-1:0]     flags_i,
  input logic [REG_W-1:0]     mask_i,
  input logic [NUM_LINES-1:0] irq_i
);
  localparam logic [REG_W-1:0] IMPL = {{(REG_W-FLAG_LO){1'b1}}, {FLAG_LO{1'b0}}};

  logic [NUM_LINES-1:0] exp_lines;
  always_comb begin
    for (int i = 0; i < NUM_LINES; i++)
      exp_lines[i] = flags_i[line_src(i)] & mask_i[line_src(i)];
  end

  logic wr_any;
  always_comb wr_any = bus_sel_i && bus_we_i;

  // R2, R9: a pulsed flag is set on the next edge, even under a clear
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(evt_set_i & IMPL) |=> ((flags_i & $past(evt_set_i & IMPL)) == $past(evt_set_i & IMPL)));

  // R4: written ones clear flags that were not pulsed at the same time
  a_r4_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_any && bus_addr_i == ADDR_FLAGS) |=> ((flags_i & $past(bus_wdata_i & ~evt_set_i)) == '0));

  // R5: mask write replaces the whole mask
  a_r5_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_any && bus_addr_i == ADDR_MASK) |=> (mask_i == $past(bus_wdata_i)));

  // R8: graceful-stop request raises flag 28 at once
  a_r8_gstop_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_any && bus_addr_i == ADDR_TXCTL && bus_wdata_i[0]) |=> flags_i[BIT_GSTOP]);

  // R3: unimplemented flag bits never rise
  a_r3_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i & ~IMPL) == '0);

  // R6, R7: lines follow the masked source flags one edge later
  a_r7_line_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_i == $past(exp_lines)));
endmodule

bind evt_irq_ctrl evt_irq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_set_i   (evt_set_i),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .flags_i     (flags_q),
  .mask_i      (mask_q),
  .irq_i       (irq_o)
);

// File: tb/evt_irq_ctrl_test.sv
`timescale 1ns/1ps
module evt_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [31:0] evt_set_i;
  logic        bus_sel_i, bus_we_i;
  logic [1:0]  bus_addr_i;
  logic [31:0] bus_wdata_i;
  logic [31:0] bus_rdata_o;
  logic [12:0] irq_o;

  int checks = 0;
  int errors = 0;
  int src_bit [13];
  logic [31:0] exp_flags, exp_mask;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  evt_irq_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_set_i(evt_set_i),
    .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  function automatic logic [12:0] lines_of(input logic [31:0] f, input logic [31:0] m);
    logic [12:0] r;
    for (int i = 0; i < 13; i++) r[i] = f[src_bit[i]] & m[src_bit[i]];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #1;
    d = bus_rdata_o;
  endtask

  // Drive at the falling edge, let the rising edge take it, release after.
  task automatic cycle(input logic [31:0] setv, input logic wr,
                       input logic [1:0] a, input logic [31:0] wd);
    @(negedge clk_i);
    evt_set_i = setv; bus_sel_i = wr; bus_we_i = wr; bus_addr_i = a; bus_wdata_i = wd;
    @(posedge clk_i);
    #1;
    evt_set_i = '0; bus_sel_i = 0; bus_we_i = 0; bus_wdata_i = '0;
  endtask

  task automatic idle();
    @(posedge clk_i);
    #1;
  endtask

  logic [31:0] d;

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    src_bit = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
    rst_ni = 0; evt_set_i = '0; bus_sel_i = 0; bus_we_i = 0;
    bus_addr_i = 0; bus_wdata_i = '0;
    repeat (3) @(posedge clk_i);
    #1;
    rd(2'd0, d); check("R1 flags in reset", d, 0);
    rd(2'd1, d); check("R1 mask in reset", d, 0);
    check("R1 lines in reset", {19'd0, irq_o}, 0);
    @(negedge clk_i); rst_ni = 1;
    idle();
    rd(2'd0, d); check("R1 flags after release", d, 0);
    check("R1 lines after release", {19'd0, irq_o}, 0);

    // R5: mask write and readback
    cycle('0, 1, 2'd1, 32'hDEAD_BEEF);
    rd(2'd1, d); check("R5 mask readback", d, 32'hDEAD_BEEF);
    cycle('0, 1, 2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); check("R5 mask replaced", d, 32'hFFFF_FFFF);
    exp_mask = 32'hFFFF_FFFF;

    // R2, R3, R6, R7: single-bit pulse sweep over all 32 positions
    for (int b = 0; b < 32; b++) begin
      exp_flags = (b >= 19) ? (32'd1 << b) : 32'd0;
      cycle(32'd1 << b, 0, 2'd0, '0);
      rd(2'd0, d); check((b >= 19) ? "R2 pulse latches" : "R3 low bit ignored", d, exp_flags);
      check("R7 lines still old", {19'd0, irq_o}, 0);
      idle();
      check("R6 line follows flag", {19'd0, irq_o}, {19'd0, lines_of(exp_flags, exp_mask)});
      cycle('0, 1, 2'd0, 32'hFFFF_FFFF);
      idle();
      check("R4 all cleared", {19'd0, irq_o}, 0);
    end

    // R6: per-line mask sweep with every flag set
    cycle(32'hFFFF_FFFF, 0, 2'd0, '0);
    exp_flags = 32'hFFF8_0000;
    for (int i = 0; i < 13; i++) begin
      cycle('0, 1, 2'd1, 32'd1 << src_bit[i]);
      idle();
      check("R6 only one line", {19'd0, irq_o}, 32'd1 << i);
      cycle('0, 1, 2'd1, ~(32'd1 << src_bit[i]));
      idle();
      check("R6 all but one line", {19'd0, irq_o}, {19'd0, ~(13'd1 << i)});
    end

    // R4: partial clear patterns
    cycle('0, 1, 2'd0, 32'hA5A5_A5A5);
    rd(2'd0, d); check("R4 partial clear", d, 32'hFFF8_0000 & ~32'hA5A5_A5A5);
    cycle('0, 1, 2'd0, 32'h0000_0000);
    rd(2'd0, d); check("R4 zero write keeps", d, 32'hFFF8_0000 & ~32'hA5A5_A5A5);
    cycle('0, 1, 2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R4 full clear", d, 0);

    // R9: set and clear on the same bit and cycle
    cycle(32'h0210_0000, 1, 2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R9 set beats clear", d, 32'h0210_0000);
    cycle('0, 1, 2'd0, 32'hFFFF_FFFF);

    // R8: graceful stop request
    cycle('0, 1, 2'd2, 32'hFFFF_FFFE);
    rd(2'd0, d); check("R8 bit0 clear no effect", d, 0);
    cycle('0, 1, 2'd2, 32'h0000_0001);
    rd(2'd0, d); check("R8 gstop flag", d, 32'h1000_0000);
    cycle('0, 1, 2'd1, 32'h1000_0000);
    idle();
    check("R8 gstop line 9", {19'd0, irq_o}, 32'h0000_0200);

    // R10: spare addresses read zero
    rd(2'd2, d); check("R10 addr2 reads zero", d, 0);
    rd(2'd3, d); check("R10 addr3 reads zero", d, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule